// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit controller core. It is purely combinational. It takes a destination operand, a source operand, a 6-bit immediate, a 3-bit operation code and the current carry bit from the status register. It returns a byte result and a packed set of six flags. Writing the flags back into the status register is the caller's job, as are the register file and sequencing.

Two operations differ from a plain byte adder. The carry-chained add takes its carry-in from the caller's status register. The word add treats `rr_i` as the high byte and `rd_i` as the low byte of a register pair and adds a zero-extended 6-bit immediate to the 16-bit value. It returns both bytes, with `res_lo_o` holding the low byte and `res_hi_o` the high byte. For every other operation `res_hi_o` is zero.

The operation codes are 0 add, 1 add with carry, 2 subtract, 3 AND, 4 OR, 5 arithmetic shift right, 6 word add and 7 AND with an immediate. The immediate AND uses `rr_i` as the constant. The flag bit positions are fixed: bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H.

Top module: `alu8_flags`

## Requirements
- R1: Code 0 gives `rd_i + rr_i` modulo 256. C (bit 0) is the carry out of bit 7 and H (bit 5) is the carry out of bit 3. `carry_i` is ignored.
- R2: Code 1 gives `rd_i + rr_i + carry_i`. C and H are the carries out of bit 7 and bit 3 of that sum.
- R3: Code 2 gives `rd_i - rr_i` modulo 256. C is set when `rd_i < rr_i` as unsigned values. H is set when the low nibble of `rd_i` is below the low nibble of `rr_i`.
- R4: V (bit 3) for codes 0 and 1 is set when both operands have the same bit 7 and the result's bit 7 differs from it. For code 2, V is set when the operands' bit 7 values differ and the result's bit 7 differs from `rd_i` bit 7.
- R5: Code 3 and code 7 give `rd_i & rr_i`, and code 4 gives `rd_i | rr_i`. For all three, V and H are 0 and C equals `carry_i`.
- R6: Code 5 gives `{rd_i[7], rd_i[7:1]}`. C is the old `rd_i[0]`, V is N XOR C, and H is 0.
- R7: Code 6 forms `{rr_i, rd_i} + kimm_i`, with `kimm_i` unsigned from 0 to 63. The low and high bytes appear on `res_lo_o` and `res_hi_o`. C is the carry out of bit 15, V is set when `rr_i[7]` is 0 and the result's bit 15 is 1, and H is 0.
- R8: Z (bit 1) is set exactly when the 8-bit result is zero, or the 16-bit result for code 6. N (bit 2) is the result's most significant bit.
- R9: S (bit 4) always equals N XOR V.
- R10: `res_hi_o` is zero for every code other than 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_i | input | 8 | Destination operand; low byte of the pair in word add |
| rr_i | input | 8 | Source operand or constant; high byte of the pair in word add |
| kimm_i | input | 6 | Unsigned immediate for word add |
| op_i | input | 3 | Operation code |
| carry_i | input | 1 | Current carry bit from the status register |
| res_lo_o | output | 8 | Byte result, or low byte of the word result |
| res_hi_o | output | 8 | High byte of the word result, zero otherwise |
| flags_o | output | 6 | {H, S, V, N, Z, C} |

## Verification
The block holds no state, so any wrong internal value shows on `res_lo_o`, `res_hi_o` or `flags_o` in the same cycle as the input pattern that exercises it. A stuck carry select in the shared adder shows as an off-by-one sum under code 1 or code 2. A bad inversion shows as swapped borrow and carry meanings. A missing high-byte propagation is only visible when the low byte of a word add wraps. For that reason the stimulus targets nibble boundaries, byte wraps, sign crossings and the 16-bit wrap, rather than arbitrary values.

// File: rtl/alu_pkg.sv
// Shared definitions for the byte ALU: operation codes and flag positions.
// Assumes a 3-bit operation code and a 6-bit packed flag vector.
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_ASR  = 3'd5,
        OP_WADD = 3'd6,
        OP_ANDK = 3'd7
    } alu_op_e;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_W = 6;

endpackage

// File: rtl/alu_add.sv
// Ripple adder with carry-in. Reports the carry out, the carry out of the
// lower half (the half-carry), and two's-complement overflow.
// Assumes W is even. A subtraction is performed by the caller, who feeds an
// inverted operand with ci = 1.
module alu_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         hc_o,
    output logic         ov_o
);
    localparam int HW = W / 2;

    logic [HW:0]   lo_part;
    logic [W-HW:0] hi_part;

    // Add the lower half first so that its carry is visible as the half-carry.
    always_comb begin
        lo_part = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + {{HW{1'b0}}, ci_i};
        hi_part = {1'b0, a_i[W-1:HW]} + {1'b0, b_i[W-1:HW]} + {{(W-HW){1'b0}}, lo_part[HW]};
    end

    // Assemble the sum and derive the carry, half-carry and overflow outputs.
    always_comb begin
        sum_o = {hi_part[W-HW-1:0], lo_part[HW-1:0]};
        co_o  = hi_part[W-HW];
        hc_o  = lo_part[HW];
        ov_o  = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise AND or OR of two operands, chosen by sel_or_i.
// Assumes the caller handles all flag policy.
module alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_or_i,
    output logic [W-1:0] y_o
);
    // Pick the requested bitwise function.
    always_comb begin
        y_o = sel_or_i ? (a_i | b_i) : (a_i & b_i);
    end
endmodule

// File: rtl/alu_asr.sv
// Arithmetic shift right by one place: the sign bit is replicated and the
// bit shifted out is returned separately.
// Assumes W >= 2.
module alu_asr #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] y_o,
    output logic         out_bit_o
);
    // Shift down while holding the top bit, and hand out the old bit 0.
    always_comb begin
        y_o       = {a_i[W-1], a_i[W-1:1]};
        out_bit_o = a_i[0];
    end
endmodule

// File: rtl/alu8_flags.sv
// Top of the byte ALU. One shared adder serves add, add with carry,
// subtract and the low byte of word add. A second adder ripples the
// low-byte carry into the high byte for word add. Flags are packed as
// {H,S,V,N,Z,C}.
// Assumes purely combinational use: the caller samples the outputs and
// writes the flags back to its status register.
module alu8_flags
    import alu_pkg::*;
#(
    parameter int DW = 8,
    parameter int KW = 6
) (
    input  logic [DW-1:0]   rd_i,
    input  logic [DW-1:0]   rr_i,
    input  logic [KW-1:0]   kimm_i,
    input  logic [2:0]      op_i,
    input  logic            carry_i,
    output logic [DW-1:0]   res_lo_o,
    output logic [DW-1:0]   res_hi_o,
    output logic [FL_W-1:0] flags_o
);
    localparam int WW = 2 * DW;

    alu_op_e op;
    logic    is_sub, is_addc, is_wadd, is_logic;

    logic [DW-1:0] add_b;
    logic          add_ci;
    logic [DW-1:0] add_sum;
    logic          add_co, add_hc, add_ov;

    logic [DW-1:0] hi_sum;
    logic          hi_co, hi_hc, hi_ov;

    logic [DW-1:0] log_y;
    logic [DW-1:0] asr_y;
    logic          asr_bit;

    logic c_f, z_f, n_f, v_f, h_f;

    // Decode the operation code into datapath controls.
    always_comb begin
        op       = alu_op_e'(op_i);
        is_sub   = (op == OP_SUB);
        is_addc  = (op == OP_ADDC);
        is_wadd  = (op == OP_WADD);
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_ANDK);
    end

    // Choose the second adder operand and the carry-in for the shared adder.
    always_comb begin
        if (is_sub) begin
            add_b  = ~rr_i;
            add_ci = 1'b1;
        end else if (is_wadd) begin
            add_b  = {{(DW-KW){1'b0}}, kimm_i};
            add_ci = 1'b0;
        end else begin
            add_b  = rr_i;
            add_ci = is_addc ? carry_i : 1'b0;
        end
    end

    alu_add #(.W(DW)) u_add_lo (
        .a_i   (rd_i),
        .b_i   (add_b),
        .ci_i  (add_ci),
        .sum_o (add_sum),
        .co_o  (add_co),
        .hc_o  (add_hc),
        .ov_o  (add_ov)
    );

    alu_add #(.W(DW)) u_add_hi (
        .a_i   (rr_i),
        .b_i   ({DW{1'b0}}),
        .ci_i  (add_co),
        .sum_o (hi_sum),
        .co_o  (hi_co),
        .hc_o  (hi_hc),
        .ov_o  (hi_ov)
    );

    alu_logic #(.W(DW)) u_logic (
        .a_i      (rd_i),
        .b_i      (rr_i),
        .sel_or_i (op == OP_OR),
        .y_o      (log_y)
    );

    alu_asr #(.W(DW)) u_asr (
        .a_i       (rd_i),
        .y_o       (asr_y),
        .out_bit_o (asr_bit)
    );

    // Select the result bytes and the per-operation carry, overflow and half flags.
    always_comb begin
        res_hi_o = '0;
        c_f      = carry_i;
        v_f      = 1'b0;
        h_f      = 1'b0;
        res_lo_o = add_sum;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                c_f = add_co;
                v_f = add_ov;
                h_f = add_hc;
            end
            OP_SUB: begin
                c_f = ~add_co;
                v_f = add_ov;
                h_f = ~add_hc;
            end
            OP_AND, OP_OR, OP_ANDK: begin
                res_lo_o = log_y;
            end
            OP_ASR: begin
                res_lo_o = asr_y;
                c_f      = asr_bit;
                v_f      = asr_y[DW-1] ^ asr_bit;
            end
            OP_WADD: begin
                res_hi_o = hi_sum;
                c_f      = hi_co;
                v_f      = hi_ov;
            end
            default: begin
                res_lo_o = add_sum;
            end
        endcase
    end

    // Derive the result-based flags and pack the flag vector.
    always_comb begin
        n_f = is_wadd ? res_hi_o[DW-1] : res_lo_o[DW-1];
        z_f = is_wadd ? ((res_lo_o | res_hi_o) == '0) : (res_lo_o == '0);
        flags_o        = '0;
        flags_o[FL_C]  = c_f;
        flags_o[FL_Z]  = z_f;
        flags_o[FL_N]  = n_f;
        flags_o[FL_V]  = v_f;
        flags_o[FL_S]  = n_f ^ v_f;
        flags_o[FL_H]  = h_f;
    end

    // Cross-check the submodule results against the operands they came from.
    always_comb begin
        if (op == OP_ADD) begin
            AST_ADD_WIDTH: assert ({flags_o[FL_C], res_lo_o} == ({1'b0, rd_i} + {1'b0, rr_i})); // R1
        end
        if (op == OP_SUB) begin
            AST_SUB_BORROW: assert (flags_o[FL_C] == (rd_i < rr_i)); // R3
        end
        if (is_logic) begin
            AST_LOGIC_CARRY: assert (flags_o[FL_C] == carry_i && !flags_o[FL_V]); // R5
        end
        if (op == OP_ASR) begin
            AST_ASR_MSB_KEPT: assert (res_lo_o[DW-1] == rd_i[DW-1]); // R6
        end
        if (is_wadd) begin
            AST_WORD_SUM: assert ({flags_o[FL_C], res_hi_o, res_lo_o} ==
                                  ({1'b0, rr_i, rd_i} + (WW+1)'(kimm_i))); // R7
        end
        if (!is_wadd) begin
            AST_BYTE_HIGH_CLEAR: assert (res_hi_o == '0); // R10
        end
    end
endmodule

// File: tb/tb_alu8_flags.sv
// Scoreboard bench: the driver computes the expected outcome from the
// requirements and queues it; the monitor compares at the falling edge.
module tb_alu8_flags;
    localparam int PERIOD = 10;

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        logic [5:0] fl;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rd, rr;
    logic [5:0] kimm;
    logic [2:0] op;
    logic       cin;
    logic [7:0] res_lo, res_hi;
    logic [5:0] flags;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    alu8_flags dut (
        .rd_i     (rd),
        .rr_i     (rr),
        .kimm_i   (kimm),
        .op_i     (op),
        .carry_i  (cin),
        .res_lo_o (res_lo),
        .res_hi_o (res_hi),
        .flags_o  (flags)
    );

    function automatic exp_t model(input logic [7:0] a, input logic [7:0] b,
                                   input logic [5:0] k, input logic [2:0] o,
                                   input logic ci);
        exp_t e;
        logic c, z, n, v, h;
        logic [8:0]  s9;
        logic [16:0] s17;
        e.hi = 8'h00;
        c = ci; v = 1'b0; h = 1'b0;
        case (o)
            3'd0, 3'd1: begin
                s9 = {1'b0, a} + {1'b0, b} + ((o == 3'd1) ? {8'd0, ci} : 9'd0);
                e.lo = s9[7:0];
                c = s9[8];
                h = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + ((o == 3'd1) ? {4'd0, ci} : 5'd0)) > 5'd15;
                v = (a[7] == b[7]) && (e.lo[7] != a[7]);
            end
            3'd2: begin
                e.lo = a - b;
                c = a < b;
                h = a[3:0] < b[3:0];
                v = (a[7] != b[7]) && (e.lo[7] != a[7]);
            end
            3'd3, 3'd7: e.lo = a & b;
            3'd4:       e.lo = a | b;
            3'd5: begin
                e.lo = {a[7], a[7:1]};
                c = a[0];
                v = e.lo[7] ^ a[0];
            end
            default: begin
                s17 = {1'b0, b, a} + {11'd0, k};
                e.lo = s17[7:0];
                e.hi = s17[15:8];
                c = s17[16];
                v = !b[7] && s17[15];
            end
        endcase
        if (o == 3'd6) begin
            n = e.hi[7];
            z = ({e.hi, e.lo} == 16'd0);
        end else begin
            n = e.lo[7];
            z = (e.lo == 8'd0);
        end
        e.fl = {h, n ^ v, v, n, z, c};
        return e;
    endfunction

    task automatic send(input logic [7:0] a, input logic [7:0] b,
                        input logic [5:0] k, input logic [2:0] o,
                        input logic ci, input string tag);
        @(posedge clk);
        #1;
        rd = a; rr = b; kimm = k; op = o; cin = ci;
        exp_q.push_back(model(a, b, k, o, ci));
        tag_q.push_back(tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Monitor: compare each queued expectation half a cycle after it was driven.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (res_lo !== e.lo || res_hi !== e.hi || flags !== e.fl) begin
                failures++;
                $display("FAIL %s: got lo=%02h hi=%02h fl=%06b expected lo=%02h hi=%02h fl=%06b",
                         t, res_lo, res_hi, flags, e.lo, e.hi, e.fl);
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got running expected finished");
            summary();
        end
    end

    initial begin
        rd = 8'h00; rr = 8'h00; kimm = 6'd0; op = 3'd0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        send(8'h00, 8'h00, 6'd0, 3'd0, 1'b0, "R8 idle zero");
        // R1 add: plain, half-carry, full wrap with carry_i ignored
        send(8'h12, 8'h34, 6'd0, 3'd0, 1'b1, "R1 plain add");
        send(8'h0F, 8'h01, 6'd0, 3'd0, 1'b0, "R1 half carry");
        send(8'h80, 8'h80, 6'd0, 3'd0, 1'b0, "R4 add both negative wrap");
        send(8'h7F, 8'h01, 6'd0, 3'd0, 1'b0, "R4 add positive overflow");
        // R2 add with carry
        send(8'hFF, 8'h00, 6'd0, 3'd1, 1'b1, "R2 carry wraps to zero");
        send(8'h10, 8'h20, 6'd0, 3'd1, 1'b0, "R2 carry clear");
        send(8'h0E, 8'h01, 6'd0, 3'd1, 1'b1, "R2 half via carry");
        // R3 subtract
        send(8'h00, 8'h01, 6'd0, 3'd2, 1'b0, "R3 borrow all ones");
        send(8'h80, 8'h01, 6'd0, 3'd2, 1'b1, "R4 sub overflow");
        send(8'h55, 8'h55, 6'd0, 3'd2, 1'b0, "R3 equal gives zero");
        send(8'h30, 8'h11, 6'd0, 3'd2, 1'b0, "R3 half borrow only");
        // R5 logic
        send(8'hF0, 8'h3C, 6'd0, 3'd3, 1'b1, "R5 and keeps carry");
        send(8'h0F, 8'hF0, 6'd0, 3'd3, 1'b0, "R5 and zero");
        send(8'h81, 8'h02, 6'd0, 3'd4, 1'b1, "R5 or negative");
        send(8'hAA, 8'hCC, 6'd0, 3'd7, 1'b0, "R5 and immediate code");
        // R6 shift
        send(8'h81, 8'h00, 6'd0, 3'd5, 1'b0, "R6 negative shift");
        send(8'h01, 8'h00, 6'd0, 3'd5, 1'b0, "R6 shift to zero");
        send(8'h40, 8'h00, 6'd0, 3'd5, 1'b1, "R6 positive no out bit");
        // R7 word add
        send(8'hFF, 8'h00, 6'd1, 3'd6, 1'b0, "R7 low byte wraps");
        send(8'hFF, 8'hFF, 6'd1, 3'd6, 1'b0, "R7 full wrap zero");
        send(8'hFF, 8'h7F, 6'd63, 3'd6, 1'b0, "R7 sign crossing");
        send(8'h00, 8'h00, 6'd0, 3'd6, 1'b1, "R8 word zero");
        send(8'h00, 8'h01, 6'd0, 3'd6, 1'b0, "R8 word nonzero high only");
        // R9 sign rule and R10 high byte stay covered above; extra pattern
        send(8'hC0, 8'h50, 6'd63, 3'd0, 1'b0, "R9 R10 sign with kimm ignored");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule